// File: doc/BRIEF.md
# Per-ID Ordered Response Scheduler

This block sits on the responding side of an on-chip read path. It takes requests that each carry an ID, a tag and a modelled service latency. It times each request in a bounded pending table and sends a response once the latency has run out. Responses for different IDs leave in completion order, so a short request can pass a long one. Responses that share an ID always leave in the order their requests were accepted, even when a later one finishes first.

Each ID has an issue counter and a retire counter. A request is stamped with its ID's issue count when it is accepted. An entry that has finished is allowed to leave only when its stamp equals its ID's retire count. Among the entries that are allowed to leave in the same cycle, the lowest table slot wins. The chosen response goes into a one-deep output register that holds it until the receiver takes it. Both channels use a VALID/READY handshake. Data contents, bursts and writes are out of scope.

Top module: `ors_sched`

## Requirements
- R1: After synchronous reset, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request is taken only on a rising edge where `req_valid` and `req_ready` are both 1. A response is consumed only on a rising edge where `rsp_valid` and `rsp_ready` are both 1, so no response is lost while `rsp_ready` is 0.
- R3: If a request with latency L is accepted on edge k, its ID has no earlier response pending and the output register is empty, then `rsp_valid` first shows that response after edge k+L+1. A latency of 0 therefore gives a response after edge k+1.
- R4: Each response returns the request's ID and tag unchanged. `rsp_seq` equals the number of earlier accepted requests with the same ID, modulo 2^SEQ_W, where SEQ_W = clog2(DEPTH)+1.
- R5: A request with a different ID that completes earlier is sent before an earlier-accepted request that is still counting down.
- R6: Responses with the same ID leave in acceptance order. A later request with the same ID that completes earlier waits until the earlier one has been placed in the output register, and it is sent on the cycle after that one.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_id`, `rsp_tag` and `rsp_seq` stay unchanged.
- R8: When all DEPTH table slots are occupied, `req_ready` is 0, and a request offered during that time is never accepted and never answered. `req_ready` returns to 1 once a slot is released.
- R9: Requests take the lowest free table slot. When several completed entries are eligible in the same cycle, the one in the lowest slot is sent first, whatever their completion order.
- R10: Every one of the 2^ID_W IDs is tracked on its own. With DEPTH of at least 2^ID_W, all IDs can be outstanding at once, and their responses leave in completion order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | A table slot is free |
| req_id | input | ID_W | Transaction ID of the request |
| req_tag | input | TAG_W | Tag returned with the response |
| req_lat | input | LAT_W | Modelled service latency in cycles |
| rsp_valid | output | 1 | Response held in the output register |
| rsp_ready | input | 1 | Receiver takes the response |
| rsp_id | output | ID_W | ID of the response |
| rsp_tag | output | TAG_W | Tag of the response |
| rsp_seq | output | SEQ_W | Per-ID sequence stamp of the response |

## Verification
The bench builds the block with ID_W=4, TAG_W=8, LAT_W=8 and DEPTH=16. This makes the table exactly as deep as the ID space, so every ID can be outstanding at once, and a latency of up to 255 keeps the whole table waiting long enough to test the full state and a rejected request. Five-bit sequence stamps let the bench follow several same-ID requests. Slots are handed out in a known order, so slot priority can be forced against completion order by holding `rsp_ready` low.

// File: rtl/ors_pkg.sv
package ors_pkg;

    // Upper bound on the pending table depth handled by the priority helper
    localparam int MAX_DEPTH = 64;

    typedef enum logic [1:0] {
        ENT_FREE = 2'd0,
        ENT_WAIT = 2'd1,
        ENT_DONE = 2'd2
    } ent_state_e;

    // Index of the least significant set bit; 0 when none is set
    function automatic int unsigned lowest_set(input logic [MAX_DEPTH-1:0] v);
        int unsigned r;
        r = 0;
        for (int i = MAX_DEPTH - 1; i >= 0; i--) begin
            if (v[i]) r = unsigned'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/ors_id_ctr.sv
module ors_id_ctr #(
    parameter int ID_W   = 4,
    parameter int SEQ_W  = 4,
    parameter int NUM_ID = 1 << ID_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             iss_en,
    input  logic [ID_W-1:0]  iss_id,
    input  logic             ret_en,
    input  logic [ID_W-1:0]  ret_id,
    output logic [SEQ_W-1:0] iss_seq,
    output logic [SEQ_W-1:0] ret_cnt [NUM_ID]
);

    logic [SEQ_W-1:0] iss_cnt [NUM_ID];

    for (genvar g = 0; g < NUM_ID; g++) begin : g_id
        logic [SEQ_W-1:0] iss_q;
        logic [SEQ_W-1:0] ret_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                iss_q <= '0;
                ret_q <= '0;
            end else begin
                if (iss_en && iss_id == ID_W'(g)) iss_q <= iss_q + SEQ_W'(1);
                if (ret_en && ret_id == ID_W'(g)) ret_q <= ret_q + SEQ_W'(1);
            end
        end

        assign iss_cnt[g] = iss_q;
        assign ret_cnt[g] = ret_q;
    end

    assign iss_seq = iss_cnt[iss_id];

    // R6
    retire_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ret_en |-> ret_cnt[ret_id] != iss_cnt[ret_id]);

endmodule

// File: rtl/ors_table.sv
module ors_table
    import ors_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int ID_W  = 4,
    parameter int TAG_W = 8,
    parameter int LAT_W = 8,
    parameter int SEQ_W = 4,
    parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_en,
    input  logic [ID_W-1:0]  alloc_id,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic [LAT_W-1:0] alloc_lat,
    input  logic [SEQ_W-1:0] alloc_seq,
    input  logic             rel_en,
    input  logic [IDX_W-1:0] rel_idx,
    output logic             has_free,
    output logic [DEPTH-1:0] done_vec,
    output logic [ID_W-1:0]  ent_id  [DEPTH],
    output logic [TAG_W-1:0] ent_tag [DEPTH],
    output logic [SEQ_W-1:0] ent_seq [DEPTH]
);

    logic [DEPTH-1:0] free_vec;
    logic [IDX_W-1:0] alloc_idx;

    assign has_free  = |free_vec;
    assign alloc_idx = IDX_W'(lowest_set(MAX_DEPTH'(free_vec)));

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        ent_state_e       st_q;
        logic [LAT_W-1:0] cnt_q;
        logic [ID_W-1:0]  id_q;
        logic [TAG_W-1:0] tag_q;
        logic [SEQ_W-1:0] seq_q;
        logic             hit_alloc;
        logic             hit_rel;

        assign hit_alloc = alloc_en && (alloc_idx == IDX_W'(g));
        assign hit_rel   = rel_en && (rel_idx == IDX_W'(g));

        // Countdown: the entry turns done on the edge where the count reaches zero
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q  <= ENT_FREE;
                cnt_q <= '0;
            end else if (hit_alloc) begin
                st_q  <= (alloc_lat == '0) ? ENT_DONE : ENT_WAIT;
                cnt_q <= alloc_lat;
            end else if (hit_rel) begin
                st_q <= ENT_FREE;
            end else if (st_q == ENT_WAIT) begin
                cnt_q <= cnt_q - LAT_W'(1);
                if (cnt_q == LAT_W'(1)) st_q <= ENT_DONE;
            end
        end

        always_ff @(posedge clk) begin
            if (hit_alloc) begin
                id_q  <= alloc_id;
                tag_q <= alloc_tag;
                seq_q <= alloc_seq;
            end
        end

        assign free_vec[g] = (st_q == ENT_FREE);
        assign done_vec[g] = (st_q == ENT_DONE);
        assign ent_id[g]   = id_q;
        assign ent_tag[g]  = tag_q;
        assign ent_seq[g]  = seq_q;
    end

    // R8
    alloc_room_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> has_free);

    // R3
    release_done_chk: assert property (@(posedge clk) disable iff (rst)
        rel_en |-> done_vec[rel_idx]);

endmodule

// File: rtl/ors_pick.sv
module ors_pick
    import ors_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    logic [N-1:0] below;

    assign any   = |req;
    assign idx   = IDX_W'(lowest_set(MAX_DEPTH'(req)));
    assign below = (N'(1) << idx) - N'(1);

    // R9
    pick_hit_chk: assert property (@(posedge clk) disable iff (rst)
        any |-> req[idx]);

    // R9
    pick_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        any |-> (req & below) == '0);

endmodule

// File: rtl/ors_sched.sv
module ors_sched
    import ors_pkg::*;
#(
    parameter int ID_W  = 4,
    parameter int TAG_W = 8,
    parameter int LAT_W = 8,
    parameter int DEPTH = 8,   // at most MAX_DEPTH
    localparam int SEQ_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ID_W-1:0]  req_id,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [LAT_W-1:0] req_lat,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [ID_W-1:0]  rsp_id,
    output logic [TAG_W-1:0] rsp_tag,
    output logic [SEQ_W-1:0] rsp_seq
);

    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NUM_ID = 1 << ID_W;

    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic [TAG_W-1:0] tag;
        logic [SEQ_W-1:0] seq;
    } rsp_t;

    logic             accept;
    logic             has_free;
    logic [SEQ_W-1:0] iss_seq;
    logic [SEQ_W-1:0] ret_cnt [NUM_ID];
    logic [DEPTH-1:0] done_vec;
    logic [ID_W-1:0]  ent_id  [DEPTH];
    logic [TAG_W-1:0] ent_tag [DEPTH];
    logic [SEQ_W-1:0] ent_seq [DEPTH];
    logic [DEPTH-1:0] elig;
    logic             pk_any;
    logic [IDX_W-1:0] pk_idx;
    logic             load;
    logic             out_full;
    rsp_t             out_q;

    assign req_ready = has_free;
    assign accept    = req_valid && req_ready;

    ors_id_ctr #(
        .ID_W   (ID_W),
        .SEQ_W  (SEQ_W),
        .NUM_ID (NUM_ID)
    ) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .iss_en  (accept),
        .iss_id  (req_id),
        .ret_en  (load),
        .ret_id  (ent_id[pk_idx]),
        .iss_seq (iss_seq),
        .ret_cnt (ret_cnt)
    );

    ors_table #(
        .DEPTH (DEPTH),
        .ID_W  (ID_W),
        .TAG_W (TAG_W),
        .LAT_W (LAT_W),
        .SEQ_W (SEQ_W),
        .IDX_W (IDX_W)
    ) u_tab (
        .clk       (clk),
        .rst       (rst),
        .alloc_en  (accept),
        .alloc_id  (req_id),
        .alloc_tag (req_tag),
        .alloc_lat (req_lat),
        .alloc_seq (iss_seq),
        .rel_en    (load),
        .rel_idx   (pk_idx),
        .has_free  (has_free),
        .done_vec  (done_vec),
        .ent_id    (ent_id),
        .ent_tag   (ent_tag),
        .ent_seq   (ent_seq)
    );

    // A finished entry may leave only when it is next in line for its ID
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            elig[i] = done_vec[i] && (ent_seq[i] == ret_cnt[ent_id[i]]);
        end
    end

    ors_pick #(
        .N     (DEPTH),
        .IDX_W (IDX_W)
    ) u_pick (
        .clk (clk),
        .rst (rst),
        .req (elig),
        .any (pk_any),
        .idx (pk_idx)
    );

    assign load = pk_any && (!out_full || rsp_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_full <= 1'b0;
            out_q    <= '0;
        end else if (load) begin
            out_full <= 1'b1;
            out_q    <= '{id: ent_id[pk_idx], tag: ent_tag[pk_idx], seq: ent_seq[pk_idx]};
        end else if (rsp_ready) begin
            out_full <= 1'b0;
        end
    end

    assign rsp_valid = out_full;
    assign rsp_id    = out_q.id;
    assign rsp_tag   = out_q.tag;
    assign rsp_seq   = out_q.seq;

    // R7
    rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(out_q));

    // R2
    rsp_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rsp_valid) |-> $past(rsp_ready));

endmodule

// File: tb/ors_sched_tb.sv
`timescale 1ns/1ps
module ors_sched_tb;

    localparam int ID_W  = 4;
    localparam int TAG_W = 8;
    localparam int LAT_W = 8;
    localparam int DEPTH = 16;
    localparam int SEQ_W = $clog2(DEPTH) + 1;
    localparam int LOGN  = 64;

    logic             clk = 1'b0;
    logic             rst;
    logic             req_valid;
    logic             req_ready;
    logic [ID_W-1:0]  req_id;
    logic [TAG_W-1:0] req_tag;
    logic [LAT_W-1:0] req_lat;
    logic             rsp_valid;
    logic             rsp_ready;
    logic [ID_W-1:0]  rsp_id;
    logic [TAG_W-1:0] rsp_tag;
    logic [SEQ_W-1:0] rsp_seq;

    always #2.5 clk = ~clk;

    ors_sched #(
        .ID_W  (ID_W),
        .TAG_W (TAG_W),
        .LAT_W (LAT_W),
        .DEPTH (DEPTH)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_id    (req_id),
        .req_tag   (req_tag),
        .req_lat   (req_lat),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_id    (rsp_id),
        .rsp_tag   (rsp_tag),
        .rsp_seq   (rsp_seq)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int exp_seq [1 << ID_W];

    int lg_id  [LOGN];
    int lg_tag [LOGN];
    int lg_seq [LOGN];
    int lg_cyc [LOGN];
    int lg_n = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Transfer monitor: a handshake seen at this falling edge completes at the next rising edge
    always @(negedge clk) begin
        if (!rst && rsp_valid && rsp_ready && lg_n < LOGN) begin
            lg_id[lg_n]  = int'(rsp_id);
            lg_tag[lg_n] = int'(rsp_tag);
            lg_seq[lg_n] = int'(rsp_seq);
            lg_cyc[lg_n] = cyc;
            lg_n = lg_n + 1;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic send(input int id, input int tag, input int lat,
                        output int acc, output int seq);
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_id    = ID_W'(id);
        req_tag   = TAG_W'(tag);
        req_lat   = LAT_W'(lat);
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        acc = cyc;
        req_valid = 1'b0;
        seq = exp_seq[id];
        exp_seq[id] = (exp_seq[id] + 1) % (1 << SEQ_W);
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < 2000 && lg_n < n; i++) @(negedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 rsp_valid after reset", int'(rsp_valid), 0);
        chk("R1 req_ready after reset", int'(req_ready), 1);
    endtask

    task automatic t_latency();
        int b, a1, s1, a2, s2, a3, s3;
        b = lg_n;
        send(1, 8'h11, 5, a1, s1);
        send(2, 8'h22, 0, a2, s2);
        wait_n(b + 2);
        chk("R3 zero-latency id", lg_id[b], 2);
        chk("R3 zero-latency cycle", lg_cyc[b], a2 + 1);
        chk("R4 tag id2", lg_tag[b], 8'h22);
        chk("R3 latency-5 cycle", lg_cyc[b+1], a1 + 6);
        chk("R4 tag id1", lg_tag[b+1], 8'h11);
        chk("R4 first seq id1", lg_seq[b+1], s1);
        send(1, 8'h13, 3, a3, s3);
        wait_n(b + 3);
        chk("R4 second seq id1", lg_seq[b+2], 1);
        chk("R3 latency-3 cycle", lg_cyc[b+2], a3 + 4);
    endtask

    task automatic t_overtake();
        int b, a1, s1, a2, s2;
        b = lg_n;
        send(5, 8'hA5, 40, a1, s1);
        send(3, 8'hA3, 2, a2, s2);
        wait_n(b + 2);
        chk("R5 fast id3 first", lg_id[b], 3);
        chk("R5 slow id5 second", lg_id[b+1], 5);
        chk("R5 slow id5 cycle", lg_cyc[b+1], a1 + 41);
    endtask

    task automatic t_same_id();
        int b, a1, s1, a2, s2;
        b = lg_n;
        send(5, 8'hB1, 30, a1, s1);
        send(5, 8'hB2, 1, a2, s2);
        wait_n(b + 2);
        chk("R6 first same-id tag", lg_tag[b], 8'hB1);
        chk("R6 second same-id tag", lg_tag[b+1], 8'hB2);
        chk("R6 first same-id cycle", lg_cyc[b], a1 + 31);
        chk("R6 second follows next cycle", lg_cyc[b+1], a1 + 32);
        chk("R4 same-id seq order", lg_seq[b+1], s2);
    endtask

    task automatic t_hold_pick();
        int b, ax, sx, ay, sy, az, sz, tg;
        b = lg_n;
        @(posedge clk); #1;
        rsp_ready = 1'b0;
        send(2, 8'hC2, 10, ax, sx);
        send(4, 8'hC4, 6, ay, sy);
        send(6, 8'hC6, 0, az, sz);
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk("R7 valid while stalled", int'(rsp_valid), 1);
        chk("R7 held id", int'(rsp_id), 6);
        tg = int'(rsp_tag);
        repeat (3) @(negedge clk);
        chk("R7 valid still held", int'(rsp_valid), 1);
        chk("R7 tag unchanged", int'(rsp_tag), tg);
        chk("R2 nothing taken without ready", lg_n, b);
        @(posedge clk); #1;
        rsp_ready = 1'b1;
        wait_n(b + 3);
        chk("R9 order first", lg_tag[b], 8'hC6);
        chk("R9 lowest slot before later completion", lg_tag[b+1], 8'hC2);
        chk("R9 order third", lg_tag[b+2], 8'hC4);
    endtask

    task automatic t_full();
        int b, a, s, seen;
        int sq [1 << ID_W];
        b = lg_n;
        @(posedge clk); #1;
        rsp_ready = 1'b0;
        for (int i = 0; i < 16; i++) begin
            send(i, 8'h40 + i, 100 - 5 * i, a, s);
            sq[i] = s;
        end
        @(negedge clk);
        chk("R8 ready low when full", int'(req_ready), 0);
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_id    = '0;
        req_tag   = 8'hEE;
        req_lat   = '0;
        repeat (5) @(negedge clk);
        chk("R8 ready stays low", int'(req_ready), 0);
        @(posedge clk); #1;
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        wait_n(b + 16);
        repeat (10) @(posedge clk);
        chk("R8 no extra response", lg_n, b + 16);
        seen = 0;
        for (int i = 0; i < 16; i++) begin
            if (lg_tag[b+i] == 8'hEE) seen++;
            chk("R10 id order", lg_id[b+i], 15 - i);
            chk("R4 seq per id", lg_seq[b+i], sq[15 - i]);
        end
        chk("R8 rejected tag absent", seen, 0);
        @(negedge clk);
        chk("R8 ready back after drain", int'(req_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << ID_W); i++) exp_seq[i] = 0;
        rst       = 1'b1;
        req_valid = 1'b0;
        req_id    = '0;
        req_tag   = '0;
        req_lat   = '0;
        rsp_ready = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        t_reset();
        t_latency();
        t_overtake();
        t_same_id();
        t_hold_pick();
        t_full();
        summary();
        $finish;
    end

endmodule